// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Core

This block is a small stored-program processor. Instructions and data share one 16-word by 8-bit memory, which sits outside the core behind a synchronous port. The core executes one instruction at a time through explicit register-transfer steps:

- the program counter is copied into the address register;
- a read is issued;
- the returned word is latched into the data register and then into the instruction register;
- the opcode is decoded;
- instructions that need memory data, or that write memory, reuse the address register for a second bus cycle;
- a final step updates the accumulator, the zero and negative flags, and the program counter.

Each instruction is one byte: the opcode is in bits 7:4 and the operand in bits 3:0. Operations include direct load and store, immediate add and subtract, branch-when-nonzero and halt. Every other opcode is a no-op. The memory returns read data one clock after a cycle in which the read request is high. A write happens at the clock edge that ends a cycle in which the write request is high.

The accumulator and both flags are brought out as ports so that the surrounding logic can observe results. The halt output tells the surrounding logic that the program has finished.

Top module: `acc_cpu`

## Requirements
- R1: While reset is active and right after it, `acc_o` is 0, `zero_o` is 1, `neg_o` is 0, `halt` is 0 and `mem_wr` is 0. One clock edge after reset is released, `mem_rd` is 1 with `mem_addr` 0.
- R2: Each instruction fetch reads the word at the program counter. It runs PC→MAR, a read cycle, memory→MDR, MDR→CIR and decode, so an instruction with no memory data access takes 6 cycles in total.
- R3: Opcode 0011 loads the accumulator from the memory word at the operand address. It takes 8 cycles, because it includes a second read cycle.
- R4: Opcode 1001 adds the zero-extended operand to the accumulator, modulo 256, in 6 cycles.
- R5: Opcode 0100 subtracts the zero-extended operand from the accumulator, modulo 256, in 6 cycles.
- R6: Opcode 1000 raises `mem_wr` for exactly one cycle, 5 cycles after its fetch begins. During that cycle `mem_addr` is the operand and `mem_wdata` is the accumulator. The whole instruction takes 6 cycles.
- R7: Only load, add and subtract write the accumulator and flags. `zero_o` is set exactly when the 8-bit result is 0, and `neg_o` equals bit 7 of the result.
- R8: Opcode 0110 loads the program counter with the operand when `zero_o` is 0. Otherwise it advances the program counter by one. It takes 6 cycles.
- R9: Every opcode other than 0011, 0100, 0110, 1000, 1001 and 1111 takes 6 cycles, advances the program counter, and leaves the accumulator and flags unchanged.
- R10: Opcode 1111 raises `halt` 5 cycles after its fetch begins. `halt` then stays high, and `mem_rd` and `mem_wr` stay low, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 4 | Memory address (MAR) |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |
| mem_wdata | output | 8 | Write data (accumulator) |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| halt | output | 1 | High once a halt instruction has been decoded |
| acc_o | output | 8 | Accumulator |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
Each program is timed from the release of reset. The bench adds the per-instruction costs (8 cycles for a load, 6 for a store, add, subtract, branch or no-op, and 5 to reach halt) and requires `halt` to rise on exactly that edge count. It also checks that the store pulse appears on the edge computed the same way. All outputs are sampled on the falling edge that follows each counted rising edge, so a result that arrives one cycle early or late shows up as a mismatch in the cycle count. Memory words, accumulator and flags are compared against sums, differences and loop counts that the bench computes arithmetically, after the core has halted.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halt,
  output logic [DW-1:0] acc_o,
  output logic          zero_o,
  output logic          neg_o
);
  localparam int OPW = DW - AW;

  localparam logic [OPW-1:0] OP_LD  = 4'b0011;
  localparam logic [OPW-1:0] OP_ADD = 4'b1001;
  localparam logic [OPW-1:0] OP_SUB = 4'b0100;
  localparam logic [OPW-1:0] OP_ST  = 4'b1000;
  localparam logic [OPW-1:0] OP_BNZ = 4'b0110;
  localparam logic [OPW-1:0] OP_HLT = 4'b1111;

  typedef enum logic [3:0] {
    S_FA, S_FR, S_FM, S_FC, S_DEC, S_OR, S_OM, S_ST, S_EX, S_HLT
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, cir, acc, alu_res;
  logic          zf, nf;

  wire [OPW-1:0] op    = cir[DW-1:AW];
  wire [AW-1:0]  arg   = cir[AW-1:0];
  wire           alu_w = (op == OP_LD) || (op == OP_ADD) || (op == OP_SUB);

  assign mem_addr  = mar;
  assign mem_wdata = acc;
  assign mem_rd    = (state == S_FR) || (state == S_OR);
  assign mem_wr    = (state == S_ST);
  assign halt      = (state == S_HLT);
  assign acc_o     = acc;
  assign zero_o    = zf;
  assign neg_o     = nf;

  always_comb begin
    case (op)
      OP_ADD:  alu_res = acc + DW'(arg);
      OP_SUB:  alu_res = acc - DW'(arg);
      default: alu_res = mdr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FA;
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      cir   <= '0;
      acc   <= '0;
      zf    <= 1'b1;
      nf    <= 1'b0;
    end else begin
      case (state)
        S_FA:  begin mar <= pc; state <= S_FR; end
        S_FR:  state <= S_FM;
        S_FM:  begin mdr <= mem_rdata; state <= S_FC; end
        S_FC:  begin cir <= mdr; state <= S_DEC; end
        S_DEC: begin
          case (op)
            OP_LD:   begin mar <= arg; state <= S_OR; end
            OP_ST:   begin mar <= arg; state <= S_ST; end
            OP_HLT:  state <= S_HLT;
            default: state <= S_EX;
          endcase
        end
        S_OR:  state <= S_OM;
        S_OM:  begin mdr <= mem_rdata; state <= S_EX; end
        S_ST:  begin pc <= pc + 1'b1; state <= S_FA; end
        S_EX:  begin
          if (alu_w) begin
            acc <= alu_res;
            zf  <= (alu_res == '0);
            nf  <= alu_res[DW-1];
          end
          if (op == OP_BNZ && !zf) pc <= arg;
          else                     pc <= pc + 1'b1;
          state <= S_FA;
        end
        default: state <= S_HLT;
      endcase
    end
  end

  assert_wr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  assert_rd_wr_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (!mem_rd && !mem_wr));
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  assert_flags_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o == (acc_o == '0)) && (neg_o == acc_o[DW-1]));
  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_EX) |=> $stable(acc_o));
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] mem_wdata;
  logic       mem_rd, mem_wr, halt, zero_o, neg_o;
  logic [7:0] acc_o;
  logic [7:0] mem [16];

  int checks = 0, fails = 0;
  int cyc, wr_cnt, wr_cyc;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  acc_cpu dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halt(halt),
    .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  endtask

  task automatic run(input int limit);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; wr_cnt = 0; wr_cyc = -1; wr_addr = 0; wr_data = 0;
    while (!halt && cyc < limit) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (mem_wr) begin
        wr_cnt++;
        if (wr_cyc < 0) begin wr_cyc = cyc; wr_addr = mem_addr; wr_data = mem_wdata; end
      end
    end
  endtask

  function automatic logic [7:0] ins(input logic [3:0] op, input logic [3:0] a);
    return {op, a};
  endfunction

  initial begin
    #(PERIOD * 195000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state and first fetch
    clear_mem();
    mem[0] = ins(4'hF, 0);
    @(negedge clk); @(negedge clk);
    chk(acc_o == 0 && zero_o && !neg_o && !halt && !mem_wr, "R1", "reset outputs",
        {acc_o, zero_o, neg_o, halt, mem_wr}, 8'h00 << 4 | 4'b1000);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(mem_rd && mem_addr == 0, "R1", "first read addr 0", {mem_rd, mem_addr}, 5'h10);
    // R10: halt timing and quiet bus
    run(100);
    chk(cyc == 5 && halt, "R10", "halt cycle", cyc, 5);
    begin
      int busy = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (mem_rd || mem_wr || !halt) busy++;
      end
      chk(busy == 0, "R10", "bus quiet after halt", busy, 0);
    end

    // R3 R4 R6 R7: load, add immediate, store sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] d, e;
        d = 8'((a * 37 + 11) & 255);
        e = d + 8'(b);
        clear_mem();
        mem[0] = ins(4'b0011, 14); mem[1] = ins(4'b1001, 4'(b));
        mem[2] = ins(4'b1000, 15); mem[3] = ins(4'hF, 0); mem[14] = d;
        run(100);
        chk(cyc == 25, "R2", "add program cycles", cyc, 25);
        chk(mem[15] == e && acc_o == e, "R4", "add result", mem[15], e);
        chk(zero_o == (e == 0) && neg_o == e[7], "R7", "add flags",
            {zero_o, neg_o}, {e == 0, e[7]});
        chk(wr_cnt == 1 && wr_cyc == 19 && wr_addr == 15 && wr_data == e, "R6",
            "store pulse", wr_cyc, 19);
      end
    end
    // R5 R7: subtract sweep including wrap and zero
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] d, e;
        d = 8'(a);
        e = d - 8'(b);
        clear_mem();
        mem[0] = ins(4'b0011, 13); mem[1] = ins(4'b0100, 4'(b));
        mem[2] = ins(4'b1000, 12); mem[3] = ins(4'hF, 0); mem[13] = d;
        run(100);
        chk(cyc == 25, "R3", "load program cycles", cyc, 25);
        chk(mem[12] == e, "R5", "sub result", mem[12], e);
        chk(zero_o == (e == 0) && neg_o == e[7], "R7", "sub flags",
            {zero_o, neg_o}, {e == 0, e[7]});
      end
    end
    // R8: countdown loop with branch-if-not-zero
    for (int n = 1; n <= 12; n++) begin
      clear_mem();
      mem[0] = ins(4'b0011, 14); mem[1] = ins(4'b0100, 1);
      mem[2] = ins(4'b1000, 14); mem[3] = ins(4'b0110, 1);
      mem[4] = ins(4'hF, 0); mem[14] = 8'(n);
      run(1000);
      chk(cyc == 13 + 18 * n, "R8", "loop cycles", cyc, 13 + 18 * n);
      chk(mem[14] == 0 && acc_o == 0 && zero_o, "R8", "loop end value", mem[14], 0);
    end
    // R9: other opcodes are no-ops; R7: flags held (negative value loaded)
    for (int o = 0; o < 16; o++) begin
      if (o == 3 || o == 4 || o == 6 || o == 8 || o == 9 || o == 15) continue;
      clear_mem();
      mem[0] = ins(4'b0011, 14); mem[1] = ins(4'(o), 4'(o));
      mem[2] = ins(4'b1000, 15); mem[3] = ins(4'hF, 0); mem[14] = 8'h9C;
      run(100);
      chk(cyc == 25, "R9", "nop cycles", cyc, 25);
      chk(mem[15] == 8'h9C && acc_o == 8'h9C && !zero_o && neg_o, "R9",
          "nop leaves state", mem[15], 8'h9C);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule